// File: doc/BRIEF.md
# Symmetric Linear-Phase FIR Filter

This block is a fully parallel FIR filter for linear-phase responses, where the coefficient for tap k is the same as the coefficient for tap TAPS-1-k. The two samples that share a coefficient are added together first, so a TAPS-tap filter needs only TAPS/2 multipliers. A direct-form filter of the same length would need one multiplier for every tap. Every tap is evaluated at once, so the block takes one signed sample per valid cycle and returns one signed result per accepted sample.

Each multiplier stage registers its pre-added sum, its product and a partial sum. The partial sums move from one stage to the next along a chain of wide adders. Each stage k delays its pre-added value by k cycles, so its product meets the partial sum that belongs to the same sample. A valid flag travels alongside the data, so the output flag marks each result after a fixed number of cycles. The coefficients are a parameter. The sample delay line moves forward only when a sample is accepted.

Top module: `symfir`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_data is 0.
- R2: Suppose in_valid is high at rising edge t. Then out_valid is high during the cycle after rising edge t+TAPS/2+2, which is 6 edges later for TAPS=8. out_valid is low in every cycle that has no such accepted sample.
- R3: The result for an accepted sample x[n] is sum over i=0..TAPS-1 of h[i]*x[n-i]. Here h[k] = h[TAPS-1-k] = COEFS[k*COEF_W +: COEF_W] for k < TAPS/2. Samples and coefficients are two's complement, and the result is exact in ACC_W bits.
- R4: A cycle with in_valid low does not change the sample history, whatever in_data holds. The next result depends only on accepted samples.
- R5: After reset, every earlier sample is treated as zero. Samples accepted before a reset have no effect on later results.
- R6: The pre-add is DATA_W+1 bits wide and does not overflow, even at the extreme sample values -2^(DATA_W-1) and 2^(DATA_W-1)-1 combined with the extreme coefficients.
- R7: Samples accepted on consecutive cycles give results on consecutive cycles, one output for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | Accept in_data on this edge |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | out_data holds a filtered result |
| out_data | output | ACC_W | Signed filtered result |

## Verification
A sample accepted at rising edge t reaches the output after edge t+TAPS/2+2. One register comes from the delay line, one from the pre-add and one from the multiply. The cascade adds TAPS/2 registers, and the valid pipe has the same depth. The bench counts rising edges and drives one sample per falling edge. For each accepted sample it records a due count of TAPS/2+3 falling edges later, together with a value from an independent convolution model. At every falling edge it compares out_valid and out_data against the head of that queue, and it flags any valid that appears when no result is due.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  // Guard bits added by the pre-adder over the input sample width.
  localparam int PRE_GUARD = 1;
  // Default arithmetic widths.
  localparam int DEF_DATA_W = 24;
  localparam int DEF_COEF_W = 18;
  localparam int DEF_ACC_W  = 48;
endpackage

// File: rtl/sfir_tapline.sv
module sfir_tapline #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        din,
  output logic [TAPS*DATA_W-1:0]   taps
);
  logic [DATA_W-1:0] line_q  [TAPS];
  logic [DATA_W-1:0] line_nx [TAPS];

  always_comb begin
    line_nx = line_q;
    if (shift_en) begin
      line_nx[0] = din;
      for (int i = 1; i < TAPS; i++) line_nx[i] = line_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) line_q[i] <= '0;
    end else begin
      line_q <= line_nx;
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_flat
    assign taps[g*DATA_W +: DATA_W] = line_q[g];
  end
endmodule

// File: rtl/sfir_stage.sv
module sfir_stage
  import sfir_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 48,
  parameter int ALIGN  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] x_near,
  input  logic [DATA_W-1:0] x_far,
  input  logic [COEF_W-1:0] coef,
  input  logic [ACC_W-1:0]  cas_in,
  output logic [ACC_W-1:0]  cas_out
);
  localparam int PRE_W = DATA_W + PRE_GUARD;

  logic [PRE_W-1:0] pre_nx, pre_q, pre_al;
  logic [ACC_W-1:0] mul_nx, mul_q, sum_nx, sum_q;

  always_comb begin
    pre_nx = {x_near[DATA_W-1], x_near} + {x_far[DATA_W-1], x_far};
    mul_nx = $signed({{(ACC_W-PRE_W){pre_al[PRE_W-1]}}, pre_al}) *
             $signed({{(ACC_W-COEF_W){coef[COEF_W-1]}}, coef});
    sum_nx = cas_in + mul_q;
  end

  // Stage k waits k cycles so its product meets the matching partial sum.
  if (ALIGN == 0) begin : g_noalign
    assign pre_al = pre_q;
  end else begin : g_align
    logic [PRE_W-1:0] al_q [ALIGN];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < ALIGN; i++) al_q[i] <= '0;
      end else begin
        al_q[0] <= pre_q;
        for (int i = 1; i < ALIGN; i++) al_q[i] <= al_q[i-1];
      end
    end
    assign pre_al = al_q[ALIGN-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      mul_q <= '0;
      sum_q <= '0;
    end else begin
      pre_q <= pre_nx;
      mul_q <= mul_nx;
      sum_q <= sum_nx;
    end
  end

  assign cas_out = sum_q;
endmodule

// File: rtl/symfir.sv
module symfir
  import sfir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = DEF_DATA_W,
  parameter int COEF_W = DEF_COEF_W,
  parameter int ACC_W  = DEF_ACC_W,
  // Entry k (k < TAPS/2) at [k*COEF_W +: COEF_W]; mirrored onto tap TAPS-1-k.
  parameter logic [(TAPS/2)*COEF_W-1:0] COEFS =
    {18'h20000, 18'h002BC, 18'h3F6D7, 18'h1FFFF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);
  localparam int HALF = TAPS / 2;
  localparam int LAT  = HALF + 3;

  logic [TAPS*DATA_W-1:0] taps;
  logic [ACC_W-1:0]       cas [HALF+1];
  logic [LAT-1:0]         vld_q, vld_nx;

  sfir_tapline #(.TAPS(TAPS), .DATA_W(DATA_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_valid),
    .din      (in_data),
    .taps     (taps)
  );

  assign cas[0] = '0;

  for (genvar k = 0; k < HALF; k++) begin : g_stage
    sfir_stage #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W),
      .ALIGN  (k)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .x_near  (taps[k*DATA_W +: DATA_W]),
      .x_far   (taps[(TAPS-1-k)*DATA_W +: DATA_W]),
      .coef    (COEFS[k*COEF_W +: COEF_W]),
      .cas_in  (cas[k]),
      .cas_out (cas[k+1])
    );
  end

  always_comb vld_nx = {vld_q[LAT-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_nx;
  end

  assign out_valid = vld_q[LAT-1];
  assign out_data  = cas[HALF];
endmodule

// File: rtl/symfir_chk.sv
module symfir_chk #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 24,
  parameter int ACC_W  = 48
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [ACC_W-1:0]       out_data,
  input logic [TAPS*DATA_W-1:0] taps
);
  localparam int LAT = TAPS / 2 + 3;

  // Independent record of which cycles accepted a sample.
  logic [LAT-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= {seen_q[LAT-2:0], in_valid};
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));

  a_r2_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q[LAT-1] |-> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q[LAT-1] |-> !out_valid);

  a_r4_history_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(taps));
endmodule

bind symfir symfir_chk #(.TAPS(TAPS), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .taps      (taps)
);

// File: tb/tb_symfir.sv
`timescale 1ns/1ps
module tb_symfir;
  localparam int TAPS = 8;
  localparam int HALF = TAPS / 2;
  localparam int LAT  = HALF + 3;
  localparam int HC [HALF] = '{131071, -2345, 700, -131072};
  localparam int NSTIM = 20;
  // {valid, sample}
  localparam logic [24:0] STIM [NSTIM] = '{
    25'h1000001, 25'h1000000, 25'h1000000, 25'h1000000, 25'h1000000,
    25'h1000000, 25'h1000000, 25'h1000000, 25'h1000000, 25'h1000000,
    25'h1000123, 25'h1FFFF00, 25'h100FFFF, 25'h17FFFFF, 25'h1800000,
    25'h1012345, 25'h1FEDCBA, 25'h1000007, 25'h1FFFFFF, 25'h1400000};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_data;
  logic        out_valid;
  logic [47:0] out_data;

  symfir dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always #2 clk = ~clk;

  typedef struct { int due; longint val; } exp_t;
  exp_t   exp_q [$];
  longint hist  [$];
  int     cyc = 0;
  int     checks = 0;
  int     failures = 0;
  string  tag = "R3";
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint coef_of(int i);
    return (i < HALF) ? longint'(HC[i]) : longint'(HC[TAPS-1-i]);
  endfunction

  task automatic accept(input logic [23:0] d);
    longint y = 0;
    exp_t   e;
    hist.push_front(longint'($signed(d)));
    if (hist.size() > TAPS) void'(hist.pop_back());
    for (int i = 0; i < hist.size(); i++) y += coef_of(i) * hist[i];
    e.due = cyc + LAT;
    e.val = y;
    exp_q.push_back(e);
  endtask

  task automatic check_outputs();
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t  e = exp_q.pop_front();
      logic [47:0] ev = e.val[47:0];
      checks++;
      if (out_valid !== 1'b1) begin
        failures++;
        $display("FAIL R2 out_valid actual=%b expected=1 at cycle %0d", out_valid, cyc);
      end else if (out_data !== ev) begin
        failures++;
        $display("FAIL %s out_data actual=%h expected=%h", tag, out_data, ev);
      end
    end else if (out_valid !== 1'b0) begin
      checks++;
      failures++;
      $display("FAIL R2 spurious out_valid actual=%b expected=0 at cycle %0d", out_valid, cyc);
    end
  endtask

  task automatic step(input bit v, input logic [23:0] d);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_data  = d;
    if (v) accept(d);
  endtask

  task automatic drain();
    repeat (LAT + 2) step(1'b0, 24'hA5A5A5);
  endtask

  task automatic check_reset_state();
    checks++;
    if (out_valid !== 1'b0 || out_data !== 48'h0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b/%h expected=0/0", out_valid, out_data);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    // R3: table walk (impulse response, then mixed values)
    tag = "R3";
    for (int i = 0; i < NSTIM; i++) step(STIM[i][24], STIM[i][23:0]);
    drain();

    // R4: idle cycles with busy in_data must not move the history
    tag = "R4";
    step(1'b1, 24'd100);
    step(1'b0, 24'h7FFFFF);
    step(1'b0, 24'h800000);
    step(1'b1, 24'hFFFFFB);
    step(1'b0, 24'h123456);
    step(1'b1, 24'd300);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 24'h3C3C3C);
      step(1'b1, 24'(i * 1111 - 2000));
    end
    drain();

    // R6: extreme samples against extreme coefficients
    tag = "R6";
    repeat (TAPS) step(1'b1, 24'h800000);
    repeat (TAPS) step(1'b1, 24'h7FFFFF);
    repeat (TAPS) step(1'b1, 24'h800000);
    drain();

    // R7: back-to-back stream, one output per input
    tag = "R7";
    for (int i = 0; i < 16; i++) step(1'b1, 24'(i * 7919 - 40000));
    drain();

    // R1 / R5: reset mid-stream, then history must start from zero
    tag = "R5";
    for (int i = 0; i < 5; i++) step(1'b1, 24'(i * 50001 + 3));
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check_reset_state();
    exp_q.delete();
    hist.delete();
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    step(1'b1, 24'd1);
    repeat (TAPS + 1) step(1'b1, 24'd0);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule